// File: doc/BRIEF.md
# Event-to-Ethernet Frame Builder

This block takes one complete detector event out of a show-ahead sample FIFO and sends it as a raw Ethernet MAC frame on a byte-wide stream, one byte per clock. Each frame carries exactly one event. No IP or UDP layer is added. The frame is made of a preamble and start delimiter, the destination and source addresses, a local EtherType, a 32-bit event number, the samples, zero padding when the frame would fall below the Ethernet minimum, and a CRC-32 frame check sequence. Physical coding and serialization happen downstream.

Every sample sits in a 16-bit little-endian slot whose unused upper bits are zero. With the default sizes, an event of 16 channels by 16 samples of 12 bits gives a 512-byte payload, so the default frame needs no padding. The builder starts a frame only after the FIFO reports that a whole event is present. A frame therefore always runs to its end. Between frames the block keeps a minimum gap of idle byte times. When the next event is already waiting, it starts again as soon as that gap ends.

Top module: `efb_frame_builder`

## Requirements
- R1: While reset is low and in the first cycle after it, tx_valid, tx_sof, tx_eof and fifo_pop are 0. The first frame after reset carries event number 0.
- R2: No frame begins while fifo_evt_avail is 0. This includes the case where the FIFO holds part of an event. No sample is popped outside a frame.
- R3: A frame opens with seven bytes 0x55 and then one byte 0xD5. tx_sof is 1 only on the first of these bytes.
- R4: Bytes 8 to 21 are the destination address, the source address and the EtherType, each sent most significant byte first.
- R5: Bytes 22 to 25 are the event number, most significant byte first. It counts frames sent since reset, starting at 0.
- R6: Each sample fills two bytes: the low 8 bits first, then the upper bits with the rest of the slot zero. Samples are sent in FIFO order. fifo_pop is 1 once per sample, during that sample's second byte, so exactly one event's worth of samples is popped per frame.
- R7: When the event number plus the samples total less than 46 bytes, zero bytes follow the samples until that total reaches 46.
- R8: The frame ends with four bytes holding the complement of the CRC-32, least significant byte first. The CRC uses reflected polynomial 0xEDB88320 (0x04C11DB7 bit-reversed) and starts from all ones. It covers every byte from the destination address through the padding. tx_eof is 1 on the last byte.
- R9: tx_valid stays 1 on every cycle from tx_sof to tx_eof.
- R10: At least IFG_BYTES cycles with tx_valid low lie between a tx_eof and the next tx_sof. If a complete event is waiting when the gap ends, exactly IFG_BYTES such cycles occur.
- R11: tx_sof, tx_eof and fifo_pop are 1 only while tx_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_sample | input | SAMPLE_W | Sample at the head of the show-ahead FIFO |
| fifo_evt_avail | input | 1 | FIFO holds at least one complete event |
| fifo_pop | output | 1 | Removes the head sample at this clock edge |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | tx_data carries a frame byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |

## Verification
The bench builds the block with 2 channels of 4 samples each. The 8 samples fill only 20 data bytes, so each frame carries 26 padding bytes and is 72 bytes long. That brings the padding path and its CRC coverage within reach, and keeps frames short enough to send many sample patterns. IFG_BYTES stays at 12, and events queued ahead of time make the exact back-to-back gap observable. The default 256-sample event has no padding. It is exercised only by elaboration.

// File: rtl/efb_pkg.sv
package efb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_HDR,
      ST_PAY,
      ST_PAD,
      ST_FCS,
      ST_GAP
   } efb_state_e;

   localparam logic [31:0] CRC_POLY_NORMAL = 32'h04C1_1DB7;
   localparam logic [31:0] CRC_INIT        = 32'hFFFF_FFFF;
   localparam logic [7:0]  PREAMBLE_BYTE   = 8'h55;
   localparam logic [7:0]  DELIM_BYTE      = 8'hD5;
   localparam int          PRE_BYTES       = 8;
   localparam int          HDR_BYTES       = 18;
   localparam int          FCS_BYTES       = 4;
   localparam int          MIN_DATA_BYTES  = 46;

   function automatic logic [31:0] bit_reverse32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = v[31-i];
      return r;
   endfunction

   localparam logic [31:0] CRC_POLY_REFL = bit_reverse32(CRC_POLY_NORMAL);

   function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
         else             r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/efb_crc32.sv
module efb_crc32
   import efb_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [31:0] crc_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)     crc_q <= CRC_INIT;
      else if (clear) crc_q <= CRC_INIT;
      else if (en)    crc_q <= crc32_byte(crc_q, din);
   end

endmodule

// File: rtl/efb_hdr_byte.sv
module efb_hdr_byte
   import efb_pkg::*;
#(
   parameter logic [47:0] DST_ADDR   = 48'h02_00_00_00_00_01,
   parameter logic [47:0] SRC_ADDR   = 48'h02_00_00_00_00_02,
   parameter logic [15:0] ETHER_TYPE = 16'h88B5,
   parameter int          IDX_W      = 5
)(
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      evt_num,
   output logic [7:0]       hdr_byte
);

   localparam int HDR_BITS = 8 * HDR_BYTES;

   logic [HDR_BITS-1:0] hdr_vec;

   always_comb begin
      hdr_vec  = {DST_ADDR, SRC_ADDR, ETHER_TYPE, evt_num};
      hdr_byte = 8'(hdr_vec >> (8 * (HDR_BYTES - 1 - int'(idx))));
   end

endmodule

// File: rtl/efb_frame_builder.sv
module efb_frame_builder
   import efb_pkg::*;
#(
   parameter int          N_CHANNELS          = 16,
   parameter int          SAMPLES_PER_CHANNEL = 16,
   parameter int          SAMPLE_W            = 12,
   parameter int          IFG_BYTES           = 12,
   parameter logic [47:0] DST_ADDR            = 48'h02_00_00_00_00_01,
   parameter logic [47:0] SRC_ADDR            = 48'h02_00_00_00_00_02,
   parameter logic [15:0] ETHER_TYPE          = 16'h88B5
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] fifo_sample,
   input  logic                fifo_evt_avail,
   output logic                fifo_pop,
   output logic [7:0]          tx_data,
   output logic                tx_valid,
   output logic                tx_sof,
   output logic                tx_eof
);

   localparam int N_SAMPLES   = N_CHANNELS * SAMPLES_PER_CHANNEL;
   localparam int PAY_BYTES   = 2 * N_SAMPLES;
   localparam int DATA_BYTES  = 4 + PAY_BYTES;
   localparam int PAD_BYTES   = (DATA_BYTES < MIN_DATA_BYTES) ? (MIN_DATA_BYTES - DATA_BYTES) : 0;
   localparam int FRAME_BYTES = PRE_BYTES + 14 + DATA_BYTES + PAD_BYTES + FCS_BYTES;
   localparam int RUN_A       = (PAY_BYTES > PAD_BYTES) ? PAY_BYTES : PAD_BYTES;
   localparam int RUN_B       = (IFG_BYTES > HDR_BYTES) ? IFG_BYTES : HDR_BYTES;
   localparam int MAX_RUN     = (RUN_A > RUN_B) ? RUN_A : RUN_B;
   localparam int CNT_W       = $clog2(MAX_RUN + 1);

   // elaboration-time parameter checks
   if (SAMPLE_W < 9 || SAMPLE_W > 16) begin : g_bad_sample_w
      $error("SAMPLE_W must lie in 9..16");
   end
   if (N_CHANNELS < 1 || SAMPLES_PER_CHANNEL < 1) begin : g_bad_event
      $error("event must hold at least one sample");
   end
   if (IFG_BYTES < 1) begin : g_bad_ifg
      $error("IFG_BYTES must be at least 1");
   end

   efb_state_e       state, nxt_state;
   logic [CNT_W-1:0] cnt, nxt_cnt;
   logic [31:0]      evt_num;
   logic [31:0]      crc_q, fcs_word;
   logic [7:0]       hdr_byte, byte_c;
   logic [15:0]      slot;
   logic             valid_c, sof_c, eof_c, pop_c;
   logic             crc_en, crc_clr, evt_inc;
   logic             pre_last, hdr_last, pay_last, pad_last, fcs_last, gap_last;
   efb_state_e       after_pay;

   efb_hdr_byte #(
      .DST_ADDR   (DST_ADDR),
      .SRC_ADDR   (SRC_ADDR),
      .ETHER_TYPE (ETHER_TYPE),
      .IDX_W      (CNT_W)
   ) u_hdr (
      .idx      (cnt),
      .evt_num  (evt_num),
      .hdr_byte (hdr_byte)
   );

   efb_crc32 u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (crc_clr),
      .en    (crc_en),
      .din   (byte_c),
      .crc_q (crc_q)
   );

   // padding variant chosen by the event size
   if (PAD_BYTES > 0) begin : g_pad
      assign pad_last  = (cnt == CNT_W'(PAD_BYTES - 1));
      assign after_pay = ST_PAD;
   end else begin : g_nopad
      assign pad_last  = 1'b1;
      assign after_pay = ST_FCS;
   end

   assign pre_last = (cnt == CNT_W'(PRE_BYTES - 1));
   assign hdr_last = (cnt == CNT_W'(HDR_BYTES - 1));
   assign pay_last = (cnt == CNT_W'(PAY_BYTES - 1));
   assign fcs_last = (cnt == CNT_W'(FCS_BYTES - 1));
   assign gap_last = (cnt == CNT_W'(IFG_BYTES - 1));
   assign slot     = 16'(fifo_sample);
   assign fcs_word = ~crc_q;

   always_comb begin
      nxt_state = state;
      nxt_cnt   = cnt + 1'b1;
      byte_c    = 8'h00;
      valid_c   = 1'b0;
      sof_c     = 1'b0;
      eof_c     = 1'b0;
      pop_c     = 1'b0;
      crc_en    = 1'b0;
      crc_clr   = 1'b0;
      evt_inc   = 1'b0;
      case (state)
         ST_IDLE: begin
            nxt_cnt = '0;
            if (fifo_evt_avail) nxt_state = ST_PRE;
         end
         ST_PRE: begin
            valid_c = 1'b1;
            sof_c   = (cnt == '0);
            byte_c  = pre_last ? DELIM_BYTE : PREAMBLE_BYTE;
            crc_clr = 1'b1;
            if (pre_last) begin
               nxt_state = ST_HDR;
               nxt_cnt   = '0;
            end
         end
         ST_HDR: begin
            valid_c = 1'b1;
            byte_c  = hdr_byte;
            crc_en  = 1'b1;
            if (hdr_last) begin
               nxt_state = ST_PAY;
               nxt_cnt   = '0;
            end
         end
         ST_PAY: begin
            valid_c = 1'b1;
            byte_c  = cnt[0] ? slot[15:8] : slot[7:0];
            pop_c   = cnt[0];
            crc_en  = 1'b1;
            if (pay_last) begin
               nxt_state = after_pay;
               nxt_cnt   = '0;
            end
         end
         ST_PAD: begin
            valid_c = 1'b1;
            crc_en  = 1'b1;
            if (pad_last) begin
               nxt_state = ST_FCS;
               nxt_cnt   = '0;
            end
         end
         ST_FCS: begin
            valid_c = 1'b1;
            byte_c  = fcs_word[8*cnt[1:0] +: 8];
            eof_c   = fcs_last;
            if (fcs_last) begin
               nxt_state = ST_GAP;
               nxt_cnt   = '0;
               evt_inc   = 1'b1;
            end
         end
         ST_GAP: begin
            if (gap_last) begin
               nxt_state = fifo_evt_avail ? ST_PRE : ST_IDLE;
               nxt_cnt   = '0;
            end
         end
         default: begin
            nxt_state = ST_IDLE;
            nxt_cnt   = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         evt_num  <= '0;
         tx_data  <= '0;
         tx_valid <= 1'b0;
         tx_sof   <= 1'b0;
         tx_eof   <= 1'b0;
      end else begin
         state    <= nxt_state;
         cnt      <= nxt_cnt;
         tx_data  <= byte_c;
         tx_valid <= valid_c;
         tx_sof   <= sof_c;
         tx_eof   <= eof_c;
         if (evt_inc) evt_num <= evt_num + 1'b1;
      end
   end

   assign fifo_pop = pop_c;

endmodule

// File: rtl/efb_frame_checker.sv
module efb_frame_checker #(
   parameter int IFG_BYTES   = 12,
   parameter int FRAME_BYTES = 64
)(
   input logic       clk,
   input logic       rst_n,
   input logic       fifo_evt_avail,
   input logic       fifo_pop,
   input logic [7:0] tx_data,
   input logic       tx_valid,
   input logic       tx_sof,
   input logic       tx_eof
);

   logic [31:0] pos;
   logic [31:0] idle_run;
   logic        seen_eof;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos      <= '0;
         idle_run <= '0;
         seen_eof <= 1'b0;
      end else begin
         if (tx_valid) begin
            pos      <= tx_sof ? 32'd1 : pos + 32'd1;
            idle_run <= '0;
         end else if (idle_run < 32'(IFG_BYTES)) begin
            idle_run <= idle_run + 32'd1;
         end
         if (tx_eof) seen_eof <= 1'b1;
      end
   end

   assert_start_needs_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sof |-> $past(fifo_evt_avail));

   assert_sof_is_preamble_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sof |-> tx_data == 8'h55);

   assert_pop_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> tx_valid);

   assert_frame_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_eof && !tx_sof) |-> pos == 32'(FRAME_BYTES - 1));

   assert_valid_unbroken_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_eof) |=> tx_valid);

   assert_min_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_sof && seen_eof) |-> idle_run >= 32'(IFG_BYTES));

   assert_marks_need_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_sof || tx_eof) |-> tx_valid);

endmodule

bind efb_frame_builder efb_frame_checker #(
   .IFG_BYTES   (IFG_BYTES),
   .FRAME_BYTES (FRAME_BYTES)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .fifo_evt_avail (fifo_evt_avail),
   .fifo_pop       (fifo_pop),
   .tx_data        (tx_data),
   .tx_valid       (tx_valid),
   .tx_sof         (tx_sof),
   .tx_eof         (tx_eof)
);

// File: tb/efb_frame_builder_tb.sv
module efb_frame_builder_tb;

   localparam int          NCH   = 2;
   localparam int          NSPC  = 4;
   localparam int          NS    = NCH * NSPC;
   localparam int          IFG   = 12;
   localparam int          FRAME = 72;
   localparam int          PAYO  = 26;
   localparam int          PADO  = PAYO + 2 * NS;
   localparam int          FCSO  = FRAME - 4;
   localparam logic [47:0] DST   = 48'h02_11_22_33_44_55;
   localparam logic [47:0] SRC   = 48'h02_AA_BB_CC_DD_EE;
   localparam logic [15:0] ETY   = 16'h88B5;
   localparam int          NVEC  = 5;
   // {first sample, sample step, queue next event early}
   localparam logic [24:0] VEC [NVEC] = '{
      {12'h000, 12'h000, 1'b0},
      {12'hFFF, 12'h000, 1'b1},
      {12'hABC, 12'h111, 1'b1},
      {12'h800, 12'hFFF, 1'b0},
      {12'h001, 12'h002, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] fifo_sample;
   logic        fifo_evt_avail;
   logic        fifo_pop;
   logic [7:0]  tx_data;
   logic        tx_valid, tx_sof, tx_eof;

   logic [11:0] fmem [64];
   logic [31:0] wr = 0, rd = 0;
   int          pops_total = 0;

   int          n_checks = 0, n_fail = 0;
   logic [7:0]  cap [FRAME + 8];
   logic [7:0]  expb [FRAME];
   int          pos = 0, cap_len = 0, idle = 0, last_gap = 0;
   int          frames_done = 0, n_sof = 0;
   bit          in_frame = 0, broken = 0;
   bit          pushed [NVEC];

   always #5 clk = ~clk;

   efb_frame_builder #(
      .N_CHANNELS          (NCH),
      .SAMPLES_PER_CHANNEL (NSPC),
      .SAMPLE_W            (12),
      .IFG_BYTES           (IFG),
      .DST_ADDR            (DST),
      .SRC_ADDR            (SRC),
      .ETHER_TYPE          (ETY)
   ) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .fifo_sample    (fifo_sample),
      .fifo_evt_avail (fifo_evt_avail),
      .fifo_pop       (fifo_pop),
      .tx_data        (tx_data),
      .tx_valid       (tx_valid),
      .tx_sof         (tx_sof),
      .tx_eof         (tx_eof)
   );

   assign fifo_sample    = fmem[rd[5:0]];
   assign fifo_evt_avail = (wr - rd) >= NS;

   always @(posedge clk) begin
      if (fifo_pop) begin
         rd         <= rd + 1;
         pops_total <= pops_total + 1;
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         in_frame = 0;
         pos      = 0;
      end else if (tx_valid) begin
         if (tx_sof) begin
            pos      = 0;
            last_gap = idle;
            n_sof++;
            in_frame = 1;
         end
         if (pos < FRAME + 8) cap[pos] = tx_data;
         pos++;
         if (tx_eof) begin
            cap_len  = pos;
            in_frame = 0;
            frames_done++;
         end
         idle = 0;
      end else begin
         if (in_frame) broken = 1;
         idle++;
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push_sample(input logic [11:0] s);
      fmem[wr[5:0]] = s;
      wr = wr + 1;
   endtask

   task automatic push_event(input logic [11:0] base, input logic [11:0] stp);
      for (int k = 0; k < NS; k++) push_sample(12'(base + 12'(k) * stp));
   endtask

   task automatic build_exp(input logic [31:0] evt, input logic [11:0] base, input logic [11:0] stp);
      logic [31:0] c;
      logic [11:0] s;
      for (int i = 0; i < 7; i++) expb[i] = 8'h55;
      expb[7] = 8'hD5;
      for (int i = 0; i < 6; i++) begin
         expb[8 + i]  = DST[47 - 8*i -: 8];
         expb[14 + i] = SRC[47 - 8*i -: 8];
      end
      expb[20] = ETY[15:8];
      expb[21] = ETY[7:0];
      for (int i = 0; i < 4; i++) expb[22 + i] = evt[31 - 8*i -: 8];
      for (int k = 0; k < NS; k++) begin
         s = 12'(base + 12'(k) * stp);
         expb[PAYO + 2*k]     = s[7:0];
         expb[PAYO + 2*k + 1] = {4'h0, s[11:8]};
      end
      for (int i = PADO; i < FCSO; i++) expb[i] = 8'h00;
      c = 32'hFFFF_FFFF;
      for (int i = 8; i < FCSO; i++)
         for (int b = 0; b < 8; b++)
            c = (c[0] ^ expb[i][b]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      c = ~c;
      for (int j = 0; j < 4; j++) expb[FCSO + j] = c[8*j +: 8];
   endtask

   task automatic check_region(input string req, input string what, input int lo, input int hi);
      int bad;
      bad = -1;
      for (int i = lo; i < hi; i++)
         if (bad < 0 && cap[i] !== expb[i]) bad = i;
      n_checks++;
      if (bad >= 0) begin
         n_fail++;
         $display("FAIL %s %s byte %0d: actual %0h expected %0h", req, what, bad, cap[bad], expb[bad]);
      end
   endtask

   task automatic wait_frames(input int target);
      while (frames_done < target) step(1);
      step(1);
   endtask

   task automatic check_frame(input logic [31:0] evt, input logic [11:0] base, input logic [11:0] stp,
                              input int pops_exp);
      build_exp(evt, base, stp);
      check("R8", "frame length", 64'(cap_len), 64'(FRAME));
      check_region("R3", "preamble", 0, 8);
      check_region("R4", "addresses and type", 8, 22);
      check_region("R5", "event number", 22, 26);
      check_region("R6", "samples", PAYO, PADO);
      check_region("R7", "padding", PADO, FCSO);
      check_region("R8", "fcs", FCSO, FRAME);
      check("R9", "valid unbroken", 64'(broken), 64'd0);
      check("R6", "pops per event", 64'(pops_total), 64'(pops_exp));
      broken = 0;
   endtask

   initial begin
      int exp_evt;
      int pop_base;
      int fdone;
      // reset state, R1
      step(3);
      check("R1", "tx_valid in reset", 64'(tx_valid), 64'd0);
      check("R1", "tx_sof in reset", 64'(tx_sof), 64'd0);
      check("R1", "fifo_pop in reset", 64'(fifo_pop), 64'd0);
      rst_n = 1'b1;
      step(1);
      check("R1", "tx_valid after reset", 64'(tx_valid), 64'd0);
      check("R1", "tx_eof after reset", 64'(tx_eof), 64'd0);

      // partial event must not start a frame, R2
      for (int k = 0; k < NS - 1; k++) push_sample(12'(12'h123 + 12'(k) * 12'h011));
      step(40);
      check("R2", "no sof on partial event", 64'(n_sof), 64'd0);
      check("R2", "no pop on partial event", 64'(pops_total), 64'd0);
      push_sample(12'(12'h123 + 12'(NS - 1) * 12'h011));
      wait_frames(1);
      check_frame(32'd0, 12'h123, 12'h011, NS);
      exp_evt = 1;

      // table of sample patterns, R3 to R10
      for (int i = 0; i < NVEC; i++) pushed[i] = 0;
      for (int i = 0; i < NVEC; i++) begin
         logic [24:0] v;
         bit early;
         v     = VEC[i];
         early = pushed[i];
         step(5);
         if (!pushed[i]) begin
            push_event(v[24:13], v[12:1]);
            pushed[i] = 1;
         end
         if (v[0] && i + 1 < NVEC) begin
            push_event(VEC[i+1][24:13], VEC[i+1][12:1]);
            pushed[i+1] = 1;
         end
         wait_frames(exp_evt + 1);
         check_frame(32'(exp_evt), v[24:13], v[12:1], NS * (exp_evt + 1));
         if (early) check("R10", "back-to-back gap", 64'(last_gap), 64'(IFG));
         else       check("R10", "gap at least minimum", 64'(last_gap >= IFG), 64'd1);
         exp_evt++;
      end

      // reset during a frame, then the event number restarts, R1 and R5
      push_event(12'h456, 12'h003);
      fdone = n_sof;
      while (n_sof == fdone) step(1);
      step(20);
      rst_n = 1'b0;
      step(1);
      check("R1", "tx_valid after mid-frame reset", 64'(tx_valid), 64'd0);
      check("R1", "fifo_pop after mid-frame reset", 64'(fifo_pop), 64'd0);
      wr = rd;
      pop_base = pops_total;
      step(2);
      rst_n = 1'b1;
      step(30);
      check("R2", "idle after reset with empty fifo", 64'(tx_valid), 64'd0);
      fdone = frames_done;
      push_event(12'hF0F, 12'h0F1);
      wait_frames(fdone + 1);
      check_frame(32'd0, 12'hF0F, 12'h0F1, pop_base + NS);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      #1_500_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule